// File: doc/BRIEF.md
# I2C Controller Status and Interrupt Flags

This block holds the status flags of an I2C controller and packs them into one status byte. A separate bus engine sends it single-cycle event strobes: a START or STOP seen on the bus, a lost arbitration, two byte-timing points (after the eighth data bit and after the acknowledge bit), a received calling address with its R/W bit, and SMBus timeout events. From these strobes the block keeps a bus-busy flag, a sticky arbitration-lost flag, a range-address-match flag, the slave direction bit, the received acknowledge level, an addressed-as-slave flag and the interrupt-pending flag.

Software clears the arbitration-lost and interrupt-pending flags by writing ones to the status byte. Any write to the control register clears the range-match flag. Address matching compares the calling address with two programmable addresses: the primary address, which is also the lower range bound, and the range address, which is the upper bound. A mode input selects whether a byte transfer raises the interrupt flag before or after the acknowledge bit. The interrupt request output is the interrupt-pending flag gated by an enable input.

Every flag is a register. A strobe present at a rising clock edge shows in the status byte after that edge. When a hardware event and a software clear of the same flag arrive in the same cycle, the event wins.

Top module: `i2c_status_flags`

## Requirements
- R1: Status bit 5 (bus busy) becomes 1 after a cycle with `ev_start` and becomes 0 after a cycle with `ev_stop` alone. If both strobes arrive in the same cycle, `ev_start` wins.
- R2: Status bit 4 (arbitration lost) becomes 1 after `ev_arb_lost`. It stays 1 until a cycle with `wr_status` and `wr_data[4]`=1. If the clear and `ev_arb_lost` arrive in the same cycle, the flag stays 1.
- R3: Status bit 3 (range match) becomes 1 after `ev_addr_valid` when `rx_addr` is nonzero and equals `range_addr`, whatever the value of `range_en`.
- R4: With `range_en`=1, status bit 3 also becomes 1 after `ev_addr_valid` when `own_addr` <= `rx_addr` < `range_addr`. With `range_en`=0, an address inside that span does not set the bit unless it equals `range_addr`.
- R5: A calling address of all zeros never sets status bit 3.
- R6: A cycle with `wr_ctrl` clears status bit 3, whatever `wr_data` holds. If a range match arrives in the same cycle, the bit is set.
- R7: Status bit 2 (slave direction) loads `rx_rw` after an `ev_addr_valid` that hits any address: primary, range, or `ext_match`. A 1 means the master reads. Otherwise the bit holds its value.
- R8: Status bit 1 (interrupt pending) is set by `ev_byte_ack` when `early_ack`=0 and by `ev_byte_data` when `early_ack`=1. The strobe that is not selected has no effect.
- R9: Status bit 1 is also set by a matching `ev_addr_valid`, by `ev_arb_lost`, and by `tmo_evt[0]`. `tmo_evt[1]` and `tmo_evt[2]` (SCL-high and SDA-high timeouts) do not set it. It is cleared by `wr_status` with `wr_data[1]`=1, and a set event in the same cycle wins.
- R10: Status bit 0 loads `rx_nack` on each `ev_byte_ack`, where 1 means a NACK was received. Otherwise it holds its value.
- R11: Status bit 6 (addressed) loads the any-address-hit result on each `ev_addr_valid`. It is cleared by `ev_stop` in a cycle without `ev_addr_valid`. Bit 7 always reads 0.
- R12: `irq` equals status bit 1 ANDed with `irq_en`, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_start | input | 1 | START detected strobe |
| ev_stop | input | 1 | STOP detected strobe |
| ev_arb_lost | input | 1 | Arbitration lost strobe |
| ev_byte_data | input | 1 | Byte done, before the acknowledge bit |
| ev_byte_ack | input | 1 | Byte done, after the acknowledge bit |
| rx_nack | input | 1 | Acknowledge level sampled with ev_byte_ack |
| ev_addr_valid | input | 1 | Calling address received strobe |
| rx_addr | input | 7 | Received calling address |
| rx_rw | input | 1 | Received R/W bit |
| ext_match | input | 1 | Hit on alert, second or general-call address, decoded elsewhere |
| tmo_evt | input | 3 | Timeout strobes: [0] interrupting, [1] SCL high, [2] SDA high |
| own_addr | input | 7 | Primary slave address and lower range bound |
| range_addr | input | 7 | Range address and upper range bound |
| range_en | input | 1 | Enables range matching |
| early_ack | input | 1 | 1: byte interrupt before the ACK bit |
| irq_en | input | 1 | Interrupt enable |
| wr_status | input | 1 | Status register write strobe (write-one-to-clear) |
| wr_ctrl | input | 1 | Control register write strobe |
| wr_data | input | 8 | Register write data |
| status | output | 8 | Packed status byte |
| irq | output | 1 | Interrupt request |

## Verification
Calling addresses are drawn mostly from a set around the two bounds: zero, one below the lower bound, the lower bound, the inside of the span, one below the upper bound, the upper bound and one above it. Each draw is tried with range matching on and off, so an off-by-one or a wrong inclusive end shows up as a wrong range-match bit. Event strobes and software writes are random and sparse, and they often meet in the same cycle, which exposes a clear that wins over a set and a START/STOP priority error. The byte-timing mode toggles during the run, so a design that ignores the mode, or lets the unselected strobe through, shows a wrong interrupt bit. Directed cases add a zero address inside an enabled range and simultaneous set/clear cycles.

// File: rtl/i2c_stat_pkg.sv
// Package: shared bit positions and the packed status layout of the
// I2C status flag block. Assumes a one-byte status word.
package i2c_stat_pkg;

    localparam int STAT_W    = 8;
    localparam int POS_NACK  = 0;
    localparam int POS_INT   = 1;
    localparam int POS_SRW   = 2;
    localparam int POS_RANGE = 3;
    localparam int POS_ARB   = 4;
    localparam int POS_BUSY  = 5;
    localparam int POS_ADDR  = 6;

    typedef struct packed {
        logic rsvd;
        logic addressed;
        logic bus_busy;
        logic arb_lost;
        logic range_hit;
        logic slv_rd;
        logic int_pend;
        logic nack_rx;
    } stat_t;

endpackage

// File: rtl/i2c_addr_match.sv
// Module: i2c_addr_match
// Compares a received calling address with the primary address and the
// range address. The range runs from the primary address (inclusive) to
// the range address (exclusive). An all-zero address never gives a range
// hit. Purely combinational; the caller qualifies with its address strobe.
module i2c_addr_match #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] cand,
    input  logic [ADDR_W-1:0] lo_addr,
    input  logic [ADDR_W-1:0] hi_addr,
    input  logic              span_en,
    input  logic              ext_hit,
    output logic              prim_hit,
    output logic              ram_hit,
    output logic              any_hit
);

    logic nonzero;
    logic eq_hi;
    logic in_span;

    // Purpose: individual comparisons against the two programmed addresses.
    always_comb begin
        nonzero = |cand;
        eq_hi   = nonzero && (cand == hi_addr);
        in_span = span_en && nonzero && (cand >= lo_addr) && (cand < hi_addr);
    end

    // Purpose: combine comparisons into the match results.
    always_comb begin
        prim_hit = (cand == lo_addr);
        ram_hit  = eq_hi || in_span;
        any_hit  = prim_hit || ram_hit || ext_hit;
    end

endmodule

// File: rtl/i2c_irq_src.sv
// Module: i2c_irq_src
// Collects the hardware events that raise the interrupt-pending flag.
// The byte-timing strobe is chosen by the early-ACK mode. Timeout strobes
// are filtered by a parameter mask. Assumes all inputs are one-cycle strobes.
module i2c_irq_src #(
    parameter int          N_TMO    = 3,
    parameter logic [N_TMO-1:0] TMO_MASK = 3'b001
) (
    input  logic             early_ack,
    input  logic             byte_pre,
    input  logic             byte_post,
    input  logic             addr_hit_ev,
    input  logic             arb_ev,
    input  logic [N_TMO-1:0] tmo_evt,
    output logic             int_set
);

    logic byte_ev;
    logic tmo_ev;

    // Purpose: pick the byte-done point and filter the timeout classes.
    always_comb begin
        byte_ev = early_ack ? byte_pre : byte_post;
        tmo_ev  = |(tmo_evt & TMO_MASK);
    end

    // Purpose: any qualifying event sets the flag.
    always_comb begin
        int_set = byte_ev || addr_hit_ev || arb_ev || tmo_ev;
    end

endmodule

// File: rtl/i2c_evt_flag.sv
// Module: i2c_evt_flag
// A sticky flag set by hardware and cleared by software. A set and a clear
// in the same cycle leave the flag set, so no event is lost.
// Synchronous active-low reset to 0.
module i2c_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);

    // Purpose: flag register, set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (set_i) begin
            q <= 1'b1;
        end else if (clr_i) begin
            q <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_status_flags.sv
// Module: i2c_status_flags (top)
// Status and interrupt flag logic of an I2C controller. Takes event strobes
// from the bus engine and register write strobes, holds the flags and
// drives a packed status byte plus a gated interrupt request.
// Assumes event and write strobes last one cycle; synchronous active-low reset.
module i2c_status_flags
    import i2c_stat_pkg::*;
#(
    parameter int          ADDR_W   = 7,
    parameter int          N_TMO    = 3,
    parameter logic [N_TMO-1:0] TMO_MASK = 3'b001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_arb_lost,
    input  logic              ev_byte_data,
    input  logic              ev_byte_ack,
    input  logic              rx_nack,
    input  logic              ev_addr_valid,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic              rx_rw,
    input  logic              ext_match,
    input  logic [N_TMO-1:0]  tmo_evt,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W-1:0] range_addr,
    input  logic              range_en,
    input  logic              early_ack,
    input  logic              irq_en,
    input  logic              wr_status,
    input  logic              wr_ctrl,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] status,
    output logic              irq
);

    logic  prim_hit, ram_hit, any_hit;
    logic  addr_hit_ev, ram_set, int_set;
    logic  clr_arb, clr_int;
    logic  busy_q, srw_q, nack_q, adr_q;
    logic  arb_q, ram_q, int_q;
    stat_t stat_s;
    logic  unused_wdata;

    i2c_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .cand     (rx_addr),
        .lo_addr  (own_addr),
        .hi_addr  (range_addr),
        .span_en  (range_en),
        .ext_hit  (ext_match),
        .prim_hit (prim_hit),
        .ram_hit  (ram_hit),
        .any_hit  (any_hit)
    );

    // Purpose: qualify the address results with the address strobe and decode clears.
    always_comb begin
        addr_hit_ev = ev_addr_valid && any_hit;
        ram_set     = ev_addr_valid && ram_hit;
        clr_arb     = wr_status && wr_data[POS_ARB];
        clr_int     = wr_status && wr_data[POS_INT];
    end

    assign unused_wdata = ^{wr_data[7:5], wr_data[3:2], wr_data[0], prim_hit};

    i2c_irq_src #(.N_TMO(N_TMO), .TMO_MASK(TMO_MASK)) u_irqsrc (
        .early_ack   (early_ack),
        .byte_pre    (ev_byte_data),
        .byte_post   (ev_byte_ack),
        .addr_hit_ev (addr_hit_ev),
        .arb_ev      (ev_arb_lost),
        .tmo_evt     (tmo_evt),
        .int_set     (int_set)
    );

    i2c_evt_flag u_arb (
        .clk (clk), .rst_n (rst_n), .set_i (ev_arb_lost), .clr_i (clr_arb), .q (arb_q)
    );
    i2c_evt_flag u_ram (
        .clk (clk), .rst_n (rst_n), .set_i (ram_set), .clr_i (wr_ctrl), .q (ram_q)
    );
    i2c_evt_flag u_int (
        .clk (clk), .rst_n (rst_n), .set_i (int_set), .clr_i (clr_int), .q (int_q)
    );

    // Purpose: bus busy tracking, START has priority over STOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (ev_start) begin
            busy_q <= 1'b1;
        end else if (ev_stop) begin
            busy_q <= 1'b0;
        end
    end

    // Purpose: slave direction and addressed flag, loaded on the address strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srw_q <= 1'b0;
            adr_q <= 1'b0;
        end else begin
            if (addr_hit_ev) begin
                srw_q <= rx_rw;
            end
            if (ev_addr_valid) begin
                adr_q <= any_hit;
            end else if (ev_stop) begin
                adr_q <= 1'b0;
            end
        end
    end

    // Purpose: capture the received acknowledge level after each ACK bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nack_q <= 1'b0;
        end else if (ev_byte_ack) begin
            nack_q <= rx_nack;
        end
    end

    // Purpose: pack the status byte and gate the interrupt request.
    always_comb begin
        stat_s.rsvd      = 1'b0;
        stat_s.addressed = adr_q;
        stat_s.bus_busy  = busy_q;
        stat_s.arb_lost  = arb_q;
        stat_s.range_hit = ram_q;
        stat_s.slv_rd    = srw_q;
        stat_s.int_pend  = int_q;
        stat_s.nack_rx   = nack_q;
        status           = stat_s;
        irq              = int_q && irq_en;
    end

    // Assertions guarding the flag behaviour.
    p_busy_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> status[POS_BUSY]);
    p_busy_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && !ev_start) |=> !status[POS_BUSY]);
    p_arb_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_arb_lost |=> status[POS_ARB]);
    p_arb_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (status[POS_ARB] && !(wr_status && wr_data[POS_ARB])) |=> status[POS_ARB]);
    p_zero_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_addr_valid && rx_addr == '0 && !status[POS_RANGE]) |=> !status[POS_RANGE]);
    p_ram_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !ev_addr_valid) |=> !status[POS_RANGE]);
    p_srw_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_addr_valid |=> $stable(status[POS_SRW]));
    p_int_arb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_arb_lost |=> status[POS_INT]);
    p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !status[7]);

endmodule

// File: tb/i2c_status_flags_bench.sv
module i2c_status_flags_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ev_start, ev_stop, ev_arb_lost, ev_byte_data, ev_byte_ack, rx_nack;
    logic       ev_addr_valid, rx_rw, ext_match;
    logic [6:0] rx_addr, own_addr, range_addr;
    logic [2:0] tmo_evt;
    logic       range_en, early_ack, irq_en, wr_status, wr_ctrl;
    logic [7:0] wr_data;
    logic [7:0] status;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // model state
    logic m_busy, m_arb, m_ram, m_srw, m_int, m_nack, m_adr;

    always #2 clk = ~clk;

    i2c_status_flags u_i2c_status_flags (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_arb_lost(ev_arb_lost), .ev_byte_data(ev_byte_data), .ev_byte_ack(ev_byte_ack),
        .rx_nack(rx_nack), .ev_addr_valid(ev_addr_valid), .rx_addr(rx_addr), .rx_rw(rx_rw),
        .ext_match(ext_match), .tmo_evt(tmo_evt), .own_addr(own_addr),
        .range_addr(range_addr), .range_en(range_en), .early_ack(early_ack),
        .irq_en(irq_en), .wr_status(wr_status), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
        .status(status), .irq(irq)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic f_ram_hit(logic [6:0] a, logic [6:0] lo, logic [6:0] hi, logic en);
        return (a != 0) && ((a == hi) || (en && a >= lo && a < hi));
    endfunction

    function automatic logic f_any_hit(logic [6:0] a, logic [6:0] lo, logic [6:0] hi,
                                       logic en, logic ex);
        return (a == lo) || f_ram_hit(a, lo, hi, en) || ex;
    endfunction

    function automatic logic [7:0] f_stat();
        return {1'b0, m_adr, m_busy, m_arb, m_ram, m_srw, m_int, m_nack};
    endfunction

    task automatic idle_inputs();
        ev_start = 0; ev_stop = 0; ev_arb_lost = 0; ev_byte_data = 0; ev_byte_ack = 0;
        rx_nack = 0; ev_addr_valid = 0; rx_rw = 0; ext_match = 0; tmo_evt = 0;
        wr_status = 0; wr_ctrl = 0; wr_data = 0; rx_addr = 0;
    endtask

    // Model update for the inputs applied in this cycle.
    task automatic model_step();
        logic any, rh, iset;
        any = f_any_hit(rx_addr, own_addr, range_addr, range_en, ext_match);
        rh  = f_ram_hit(rx_addr, own_addr, range_addr, range_en);
        iset = (early_ack ? ev_byte_data : ev_byte_ack) | (ev_addr_valid & any)
             | ev_arb_lost | tmo_evt[0];
        if (ev_start) m_busy = 1; else if (ev_stop) m_busy = 0;
        if (ev_arb_lost) m_arb = 1; else if (wr_status && wr_data[4]) m_arb = 0;
        if (ev_addr_valid && rh) m_ram = 1; else if (wr_ctrl) m_ram = 0;
        if (ev_addr_valid && any) m_srw = rx_rw;
        if (iset) m_int = 1; else if (wr_status && wr_data[1]) m_int = 0;
        if (ev_byte_ack) m_nack = rx_nack;
        if (ev_addr_valid) m_adr = any; else if (ev_stop) m_adr = 0;
    endtask

    task automatic compare_all();
        logic [7:0] e;
        e = f_stat();
        chk(status[5] == e[5], "R1 busy", status[5], e[5]);
        chk(status[4] == e[4], "R2 arb_lost", status[4], e[4]);
        chk(status[3] == e[3], "R3/R4/R5/R6 range_match", status[3], e[3]);
        chk(status[2] == e[2], "R7 slave_dir", status[2], e[2]);
        chk(status[1] == e[1], "R8/R9 int_pend", status[1], e[1]);
        chk(status[0] == e[0], "R10 rx_nack", status[0], e[0]);
        chk(status[7:6] == e[7:6], "R11 addressed/rsvd", status[7:6], e[7:6]);
    endtask

    // Apply the current input values for one clock, then check.
    task automatic apply();
        #1;
        chk(irq == (m_int & irq_en), "R12 irq", irq, m_int & irq_en);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [6:0] pick_addr();
        case ($urandom % 9)
            0: return 7'd0;
            1: return own_addr - 7'd1;
            2: return own_addr;
            3: return own_addr + 7'd3;
            4: return range_addr - 7'd1;
            5: return range_addr;
            6: return range_addr + 7'd1;
            default: return 7'($urandom);
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0;
        idle_inputs();
        own_addr = 7'h10; range_addr = 7'h18; range_en = 1; early_ack = 0; irq_en = 1;
        {m_busy, m_arb, m_ram, m_srw, m_int, m_nack, m_adr} = '0;
        repeat (3) @(negedge clk);
        chk(status == 8'h00, "R1..reset status", status, 0);
        chk(irq == 1'b0, "R12 reset irq", irq, 0);
        rst_n = 1;

        // Directed: zero address in an enabled range starting at 0 (R5).
        own_addr = 7'h00; range_addr = 7'h05;
        ev_addr_valid = 1; rx_addr = 7'h00; apply();
        chk(status[3] == 1'b0, "R5 zero address no range match", status[3], 0);
        idle_inputs(); wr_status = 1; wr_data = 8'h02; apply();

        // Directed: lower bound inclusive, upper exclusive with equality (R4, R3).
        own_addr = 7'h10; range_addr = 7'h18;
        idle_inputs(); ev_addr_valid = 1; rx_addr = 7'h10; apply();
        chk(status[3] == 1'b1, "R4 lower bound inclusive", status[3], 1);
        idle_inputs(); wr_ctrl = 1; wr_data = 8'h5A; apply();
        chk(status[3] == 1'b0, "R6 control write clears", status[3], 0);
        range_en = 0;
        idle_inputs(); ev_addr_valid = 1; rx_addr = 7'h14; apply();
        chk(status[3] == 1'b0, "R4 span ignored when disabled", status[3], 0);
        idle_inputs(); ev_addr_valid = 1; rx_addr = 7'h18; rx_rw = 1; apply();
        chk(status[3] == 1'b1, "R3 equal to range address", status[3], 1);
        chk(status[2] == 1'b1, "R7 slave transmit", status[2], 1);

        // Directed: set wins over clear (R2, R9, R6) and START over STOP (R1).
        idle_inputs(); ev_arb_lost = 1; wr_status = 1; wr_data = 8'h12;
        ev_addr_valid = 1; rx_addr = 7'h18; wr_ctrl = 1; ev_start = 1; ev_stop = 1; apply();
        chk(status[4] == 1'b1, "R2 set wins", status[4], 1);
        chk(status[5] == 1'b1, "R1 start wins", status[5], 1);
        chk(status[3] == 1'b1, "R6 set wins", status[3], 1);

        // Directed: quiet timeouts and unselected byte strobe (R9, R8).
        idle_inputs(); wr_status = 1; wr_data = 8'hFF; apply();
        idle_inputs(); tmo_evt = 3'b110; ev_byte_data = 1; early_ack = 0; apply();
        chk(status[1] == 1'b0, "R9/R8 no interrupt", status[1], 0);
        idle_inputs(); early_ack = 1; ev_byte_data = 1; irq_en = 0; apply();
        chk(status[1] == 1'b1, "R8 early byte interrupt", status[1], 1);
        idle_inputs(); irq_en = 1; apply();
        chk(irq == 1'b1, "R12 enabled irq", irq, 1);

        // Random phase.
        for (int i = 0; i < 3000; i++) begin
            idle_inputs();
            if ($urandom % 200 == 0) begin
                own_addr = 7'($urandom); range_addr = 7'($urandom);
            end
            if ($urandom % 50 == 0) early_ack = ~early_ack;
            range_en = ($urandom % 3) != 0;
            irq_en = ($urandom % 4) != 0;
            ev_start = ($urandom % 8) == 0;
            ev_stop = ($urandom % 8) == 0;
            ev_arb_lost = ($urandom % 16) == 0;
            ev_byte_data = ($urandom % 6) == 0;
            ev_byte_ack = ($urandom % 6) == 0;
            rx_nack = 1'($urandom);
            ev_addr_valid = ($urandom % 4) == 0;
            rx_addr = pick_addr();
            rx_rw = 1'($urandom);
            ext_match = ($urandom % 10) == 0;
            tmo_evt = (($urandom % 8) == 0) ? 3'($urandom) : 3'b000;
            wr_status = ($urandom % 5) == 0;
            wr_ctrl = ($urandom % 7) == 0;
            wr_data = 8'($urandom);
            apply();
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule